// File: doc/BRIEF.md
# Serial Character Receiver with Break and Sync Detection

This block is the receive half of a programmable serial port. It samples a serial input line on a receive tick. It builds characters of 5 to 8 bits, with optional parity, and holds each finished character in a data register with a ready flag for the processor. If a new character finishes before the processor has read the previous one, the older value is lost and an overrun flag is raised. Parity and framing problems are kept in sticky error flags. A sequencer command clears these flags.

One pin changes role with the operating mode. In asynchronous mode it is an output that reports a break: a character that is all zero and ends with a low stop bit. It stays high until the line returns high. In internal synchronous mode it is an output that goes high when the receiver finds its programmed sync character while hunting. A status read clears it. In external synchronous mode the pin is an input, and a high level on it ends the hunt so that character assembly begins.

Asynchronous mode divides the tick by 16 or 64. It confirms a start bit at its middle and samples every later bit at its centre. The synchronous modes take one bit on every tick.

Top module: `ser_rx_top`

## Requirements
- R1: Asynchronous mode (`cfg_mode`=0) receives characters LSB first. Each bit lasts 16 ticks (`cfg_div64`=0) or 64 ticks (`cfg_div64`=1). The length is 5+`cfg_len` bits, right-justified in `rx_data` with the upper bits zero.
- R2: In asynchronous mode, a low level that is gone by the middle of the start bit is not a start bit. No character is produced, and `rx_data` and `char_ready` are left unchanged.
- R3: `char_ready` rises after each completed character and falls after a one-cycle `rd_data` pulse. After reset, `char_ready`, `rx_data` and every flag are 0.
- R4: If a character completes while `char_ready` is still set and not being read, `rx_data` takes the new character and `overrun` goes to 1.
- R5: With `cfg_par_en`=1, a parity bit follows the data. Even parity (`cfg_par_odd`=0) expects an even count of ones over data plus parity bit, and odd parity expects an odd count. A mismatch sets `parity_err`. This applies in all modes.
- R6: In asynchronous mode, a low stop bit sets `framing_err`. The character is still delivered.
- R7: In asynchronous mode, `lev_out` goes high after a character with all-zero data (and a zero parity bit, if parity is enabled) and a low stop bit. It falls once the line is sampled high on a tick. A framing error with nonzero data leaves `lev_out` low.
- R8: In internal synchronous mode (`cfg_mode`=1), a `cmd_hunt` pulse starts a hunt. One bit is taken per tick. When the last 5+`cfg_len` bits, oldest as LSB, equal the low bits of `cfg_sync_char`, `lev_out` goes high, and the following bits are assembled into characters without delivering the sync character itself.
- R9: In internal synchronous mode, a `rd_status` pulse clears `lev_out`.
- R10: In external synchronous mode (`cfg_mode`=2), `lev_oe` is 0 and ticks during the hunt produce no characters. A high `lev_in` ends the hunt, and the following ticks carry character bits.
- R11: A `cmd_err_clr` pulse clears `overrun`, `parity_err` and `framing_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_tick | input | 1 | One-cycle pulse per receive clock period |
| ser_in | input | 1 | Serial data line |
| cfg_mode | input | 2 | 0 async, 1 internal sync, 2 external sync |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even |
| cfg_div64 | input | 1 | Async bit length: 0 = 16 ticks, 1 = 64 ticks |
| cfg_sync_char | input | 8 | Sync character for internal hunt |
| cmd_hunt | input | 1 | Restart sync hunt |
| cmd_err_clr | input | 1 | Clear error flags |
| rd_data | input | 1 | Processor data read strobe |
| rd_status | input | 1 | Processor status read strobe |
| lev_in | input | 1 | External sync input (mode 2) |
| lev_out | output | 1 | Break or sync-detect indication |
| lev_oe | output | 1 | Drive enable for the shared pin |
| rx_data | output | 8 | Last received character |
| char_ready | output | 1 | Character waiting to be read |
| overrun | output | 1 | Character lost |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | Low stop bit seen |

## Verification
The assertions watch the flag register logic on every cycle. A finished character always sets the ready flag. A finish while the flag is still set and unread always raises overrun. The read, status-read and error-clear strobes always take effect on the next cycle. The assertions also check that a start bit which is gone by mid-bit returns the receiver to idle, that a break indication is only held while the receiver waits for the line to go high, and that an external sync pulse ends the hunt. The bench scenarios are what show that bits are taken at the right centres, in the right order and at the right length for each divider. They also show that parity and sync-character matching compute the correct result, and that glitches, breaks and ticks seen during a hunt leave the outputs as required.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
    localparam int RX_DW      = 8;
    localparam int RX_LEN_MIN = 5;
    localparam int DIV_LO     = 16;
    localparam int DIV_HI     = 64;
    localparam int CNT_W      = $clog2(DIV_HI);
    localparam int IDX_W      = $clog2(RX_DW);

    typedef enum logic [1:0] {
        RX_ASYNC    = 2'd0,
        RX_SYNC_INT = 2'd1,
        RX_SYNC_EXT = 2'd2
    } rx_mode_e;
endpackage

// File: rtl/ser_rx_async.sv
module ser_rx_async
    import ser_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             rxd,
    input  logic             div64,
    input  logic [1:0]       len,
    input  logic             par_en,
    input  logic             par_odd,
    output logic             done,
    output logic [RX_DW-1:0] data,
    output logic             par_bad,
    output logic             frm_bad,
    output logic             brk
);
    typedef enum logic [2:0] {A_IDLE, A_START, A_DATA, A_PAR, A_STOP, A_WAIT} ast_e;

    typedef struct packed {
        ast_e             st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [RX_DW-1:0] sh;
        logic             pbit;
        logic             done;
        logic [RX_DW-1:0] data;
        logic             par_bad;
        logic             frm_bad;
        logic             brk;
    } ast_t;

    ast_t q, d;
    logic [CNT_W-1:0] lim_full, lim_half;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] shamt;
    logic [RX_DW-1:0] chr;

    always_comb begin
        lim_full = div64 ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
        lim_half = div64 ? CNT_W'(DIV_HI / 2 - 1) : CNT_W'(DIV_LO / 2 - 1);
        last_idx = IDX_W'(RX_LEN_MIN - 1) + IDX_W'(len);
        shamt    = IDX_W'(RX_DW - RX_LEN_MIN) - IDX_W'(len);
        chr      = q.sh >> shamt;
        d        = q;
        d.done   = 1'b0;
        if (!active) begin
            d.st  = A_IDLE;
            d.cnt = '0;
            d.brk = 1'b0;
        end else if (tick) begin
            case (q.st)
                A_IDLE: if (!rxd) begin
                    d.st  = A_START;
                    d.cnt = '0;
                end
                A_START: begin
                    if (q.cnt == lim_half) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = rxd ? A_IDLE : A_DATA;
                    end else d.cnt = q.cnt + 1'b1;
                end
                A_DATA: begin
                    if (q.cnt == lim_full) begin
                        d.cnt = '0;
                        d.sh  = {rxd, q.sh[RX_DW-1:1]};
                        if (q.idx == last_idx) d.st = par_en ? A_PAR : A_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end else d.cnt = q.cnt + 1'b1;
                end
                A_PAR: begin
                    if (q.cnt == lim_full) begin
                        d.cnt  = '0;
                        d.pbit = rxd;
                        d.st   = A_STOP;
                    end else d.cnt = q.cnt + 1'b1;
                end
                A_STOP: begin
                    if (q.cnt == lim_full) begin
                        d.cnt     = '0;
                        d.done    = 1'b1;
                        d.data    = chr;
                        d.par_bad = par_en & (^chr ^ q.pbit ^ par_odd);
                        d.frm_bad = ~rxd;
                        if (!rxd) begin
                            d.st  = A_WAIT;
                            d.brk = (chr == '0) && !(par_en && q.pbit);
                        end else d.st = A_IDLE;
                    end else d.cnt = q.cnt + 1'b1;
                end
                A_WAIT: if (rxd) begin
                    d.st  = A_IDLE;
                    d.brk = 1'b0;
                end
                default: d.st = A_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= A_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign data    = q.data;
    assign par_bad = q.par_bad;
    assign frm_bad = q.frm_bad;
    assign brk     = q.brk;

    // A start bit that has gone high by mid-bit returns the receiver to idle.
    assert_false_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && q.st == A_START && q.cnt == lim_half && rxd)
        |=> (q.st == A_IDLE && !q.done));

    // The break indication is held only while waiting for the line to go high.
    assert_brk_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.brk |-> q.st == A_WAIT);
endmodule

// File: rtl/ser_rx_sync.sv
module ser_rx_sync
    import ser_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             ext,
    input  logic             hunt_cmd,
    input  logic             tick,
    input  logic             rxd,
    input  logic             sync_in,
    input  logic [1:0]       len,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic [RX_DW-1:0] sync_char,
    output logic             done,
    output logic [RX_DW-1:0] data,
    output logic             par_bad,
    output logic             found
);
    typedef enum logic [1:0] {S_HUNT, S_DATA, S_PAR} sst_e;

    typedef struct packed {
        sst_e             st;
        logic [IDX_W-1:0] idx;
        logic [RX_DW-1:0] win;
        logic [RX_DW-1:0] sh;
        logic             done;
        logic [RX_DW-1:0] data;
        logic             par_bad;
        logic             found;
    } sst_t;

    sst_t q, d;
    logic [IDX_W-1:0] last_idx, shamt;
    logic [RX_DW-1:0] win_n, sh_n, mask;

    always_comb begin
        last_idx = IDX_W'(RX_LEN_MIN - 1) + IDX_W'(len);
        shamt    = IDX_W'(RX_DW - RX_LEN_MIN) - IDX_W'(len);
        mask     = {RX_DW{1'b1}} >> shamt;
        win_n    = {rxd, q.win[RX_DW-1:1]};
        sh_n     = {rxd, q.sh[RX_DW-1:1]};
        d        = q;
        d.done   = 1'b0;
        d.found  = 1'b0;
        if (!active || hunt_cmd) begin
            d.st  = S_HUNT;
            d.win = '0;
            d.idx = '0;
        end else begin
            case (q.st)
                S_HUNT: begin
                    if (ext) begin
                        if (sync_in) begin
                            d.st  = S_DATA;
                            d.idx = '0;
                        end
                    end else if (tick) begin
                        d.win = win_n;
                        if ((win_n >> shamt) == (sync_char & mask)) begin
                            d.found = 1'b1;
                            d.st    = S_DATA;
                            d.idx   = '0;
                        end
                    end
                end
                S_DATA: if (tick) begin
                    d.sh = sh_n;
                    if (q.idx == last_idx) begin
                        d.idx = '0;
                        if (par_en) d.st = S_PAR;
                        else begin
                            d.done    = 1'b1;
                            d.data    = sh_n >> shamt;
                            d.par_bad = 1'b0;
                        end
                    end else d.idx = q.idx + 1'b1;
                end
                S_PAR: if (tick) begin
                    d.st      = S_DATA;
                    d.done    = 1'b1;
                    d.data    = q.sh >> shamt;
                    d.par_bad = ^(q.sh >> shamt) ^ rxd ^ par_odd;
                end
                default: d.st = S_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_HUNT;
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign data    = q.data;
    assign par_bad = q.par_bad;
    assign found   = q.found;

    // An external sync pulse during the hunt starts character assembly.
    assert_ext_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ext && !hunt_cmd && q.st == S_HUNT && sync_in) |=> q.st == S_DATA);
endmodule

// File: rtl/ser_rx_flags.sv
module ser_rx_flags
    import ser_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [RX_DW-1:0] data_i,
    input  logic             par_bad_i,
    input  logic             frm_bad_i,
    input  logic             found_i,
    input  logic             int_mode_i,
    input  logic             rd_data_i,
    input  logic             rd_status_i,
    input  logic             err_clr_i,
    output logic             rdy_o,
    output logic [RX_DW-1:0] data_o,
    output logic             ovr_o,
    output logic             perr_o,
    output logic             ferr_o,
    output logic             sdet_o
);
    typedef struct packed {
        logic             rdy;
        logic [RX_DW-1:0] data;
        logic             ovr;
        logic             perr;
        logic             ferr;
        logic             sdet;
    } flg_t;

    flg_t q, d;

    always_comb begin
        d = q;
        if (err_clr_i) begin
            d.ovr  = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
        end
        if (done_i) begin
            d.data = data_i;
            d.rdy  = 1'b1;
            if (q.rdy && !rd_data_i) d.ovr = 1'b1;
            if (par_bad_i) d.perr = 1'b1;
            if (frm_bad_i) d.ferr = 1'b1;
        end else if (rd_data_i) begin
            d.rdy = 1'b0;
        end
        if (!int_mode_i)      d.sdet = 1'b0;
        else if (found_i)     d.sdet = 1'b1;
        else if (rd_status_i) d.sdet = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdy_o  = q.rdy;
    assign data_o = q.data;
    assign ovr_o  = q.ovr;
    assign perr_o = q.perr;
    assign ferr_o = q.ferr;
    assign sdet_o = q.sdet;

    assert_ready_on_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> q.rdy);
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && !done_i) |=> !q.rdy);
    assert_overrun_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && q.rdy && !rd_data_i) |=> q.ovr);
    assert_errclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !done_i) |=> (!q.ovr && !q.perr && !q.ferr));
    assert_sync_found_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (found_i && int_mode_i) |=> q.sdet);
    assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status_i && !found_i) |=> !q.sdet);
endmodule

// File: rtl/ser_rx_top.sv
module ser_rx_top
    import ser_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_tick,
    input  logic             ser_in,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_div64,
    input  logic [RX_DW-1:0] cfg_sync_char,
    input  logic             cmd_hunt,
    input  logic             cmd_err_clr,
    input  logic             rd_data,
    input  logic             rd_status,
    input  logic             lev_in,
    output logic             lev_out,
    output logic             lev_oe,
    output logic [RX_DW-1:0] rx_data,
    output logic             char_ready,
    output logic             overrun,
    output logic             parity_err,
    output logic             framing_err
);
    logic             is_async, is_int, is_ext;
    logic             a_done, a_pbad, a_fbad, a_brk;
    logic [RX_DW-1:0] a_data;
    logic             s_done, s_pbad, s_found;
    logic [RX_DW-1:0] s_data;
    logic             m_done, m_pbad, m_fbad;
    logic [RX_DW-1:0] m_data;
    logic             sdet;

    assign is_async = (cfg_mode == RX_ASYNC);
    assign is_int   = (cfg_mode == RX_SYNC_INT);
    assign is_ext   = (cfg_mode == RX_SYNC_EXT);

    ser_rx_async u_async (
        .clk(clk), .rst_n(rst_n), .active(is_async), .tick(rx_tick), .rxd(ser_in),
        .div64(cfg_div64), .len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .done(a_done), .data(a_data), .par_bad(a_pbad), .frm_bad(a_fbad), .brk(a_brk)
    );

    ser_rx_sync u_sync (
        .clk(clk), .rst_n(rst_n), .active(is_int || is_ext), .ext(is_ext),
        .hunt_cmd(cmd_hunt), .tick(rx_tick), .rxd(ser_in), .sync_in(lev_in),
        .len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .sync_char(cfg_sync_char), .done(s_done), .data(s_data),
        .par_bad(s_pbad), .found(s_found)
    );

    assign m_done = is_async ? a_done : s_done;
    assign m_data = is_async ? a_data : s_data;
    assign m_pbad = is_async ? a_pbad : s_pbad;
    assign m_fbad = is_async & a_fbad;

    ser_rx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .done_i(m_done), .data_i(m_data),
        .par_bad_i(m_pbad), .frm_bad_i(m_fbad), .found_i(s_found),
        .int_mode_i(is_int), .rd_data_i(rd_data), .rd_status_i(rd_status),
        .err_clr_i(cmd_err_clr), .rdy_o(char_ready), .data_o(rx_data),
        .ovr_o(overrun), .perr_o(parity_err), .ferr_o(framing_err), .sdet_o(sdet)
    );

    assign lev_out = is_async ? a_brk : (is_int ? sdet : 1'b0);
    assign lev_oe  = !is_ext;
endmodule

// File: tb/ser_rx_top_bench.sv
module ser_rx_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0, ser_in = 1'b1;
    logic [1:0] cfg_mode = 2'd0, cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_div64 = 1'b0;
    logic [7:0] cfg_sync_char = 8'h00;
    logic       cmd_hunt = 1'b0, cmd_err_clr = 1'b0, rd_data = 1'b0, rd_status = 1'b0;
    logic       lev_in = 1'b0;
    logic       lev_out, lev_oe, char_ready, overrun, parity_err, framing_err;
    logic [7:0] rx_data;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ser_rx_top u_ser_rx_top (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .ser_in(ser_in),
        .cfg_mode(cfg_mode), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_div64(cfg_div64), .cfg_sync_char(cfg_sync_char),
        .cmd_hunt(cmd_hunt), .cmd_err_clr(cmd_err_clr), .rd_data(rd_data),
        .rd_status(rd_status), .lev_in(lev_in), .lev_out(lev_out), .lev_oe(lev_oe),
        .rx_data(rx_data), .char_ready(char_ready), .overrun(overrun),
        .parity_err(parity_err), .framing_err(framing_err)
    );

    function automatic logic [7:0] len_mask(input logic [1:0] l);
        return 8'hFF >> (3 - l);
    endfunction

    function automatic logic par_bit(input logic [7:0] v, input logic [1:0] l, input logic odd);
        return ^(v & len_mask(l)) ^ odd;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_tick = 1'b1;
            @(negedge clk); rx_tick = 1'b0;
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic send_async(input logic [7:0] v, input logic stop, input logic flip_par);
        int f;
        f = cfg_div64 ? 64 : 16;
        ser_in = 1'b0; ticks(f);
        for (int i = 0; i < 5 + cfg_len; i++) begin ser_in = v[i]; ticks(f); end
        if (cfg_par_en) begin ser_in = par_bit(v, cfg_len, cfg_par_odd) ^ flip_par; ticks(f); end
        ser_in = stop; ticks(f);
        ticks(2);
    endtask

    task automatic sync_bit(input logic b);
        @(negedge clk); ser_in = b; rx_tick = 1'b1;
        @(negedge clk); rx_tick = 1'b0;
    endtask

    task automatic send_sync(input logic [7:0] v, input logic flip_par);
        for (int i = 0; i < 5 + cfg_len; i++) sync_bit(v[i]);
        if (cfg_par_en) sync_bit(par_bit(v, cfg_len, cfg_par_odd) ^ flip_par);
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        // R3: reset state
        check("R3 reset ready", char_ready, 0);
        check("R3 reset data", rx_data, 0);
        check("R3 reset flags", {overrun, parity_err, framing_err, lev_out}, 0);
        rst_n = 1'b1;
        ticks(3);

        // R1: 8-bit, x16, no parity
        send_async(8'hA5, 1'b1, 1'b0);
        check("R1 data A5", rx_data, 8'hA5);
        check("R3 ready set", char_ready, 1);
        check("R6 no framing", framing_err, 0);
        pulse(rd_data);
        check("R3 read clears", char_ready, 0);

        // R1/R5: 5-bit even parity
        cfg_len = 2'd0; cfg_par_en = 1'b1;
        send_async(8'h13, 1'b1, 1'b0);
        check("R1 5-bit data", rx_data, 8'h13);
        check("R5 even ok", parity_err, 0);
        pulse(rd_data);

        // R1/R5: x64, odd parity, 7 bits
        cfg_div64 = 1'b1; cfg_len = 2'd2; cfg_par_odd = 1'b1;
        send_async(8'h5A, 1'b1, 1'b0);
        check("R1 x64 data", rx_data, 8'h5A);
        check("R5 odd ok", parity_err, 0);
        pulse(rd_data);
        cfg_div64 = 1'b0; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R2: short low glitch
        ser_in = 1'b0; ticks(4); ser_in = 1'b1; ticks(40);
        check("R2 glitch no char", char_ready, 0);
        check("R2 glitch data kept", rx_data, 8'h5A);
        send_async(8'h3C, 1'b1, 1'b0);
        check("R2 next char ok", rx_data, 8'h3C);
        pulse(rd_data);

        // R5: bad parity, R11 clear
        cfg_par_en = 1'b1;
        send_async(8'h71, 1'b1, 1'b1);
        check("R5 parity error", parity_err, 1);
        check("R5 data kept", rx_data, 8'h71);
        pulse(rd_data);
        pulse(cmd_err_clr);
        check("R11 parity cleared", parity_err, 0);
        cfg_par_en = 1'b0;

        // R6: low stop, nonzero data -> no break
        send_async(8'h81, 1'b0, 1'b0);
        check("R6 framing error", framing_err, 1);
        check("R7 no break on nonzero", lev_out, 0);
        check("R6 data delivered", rx_data, 8'h81);
        ser_in = 1'b1; ticks(3);
        pulse(rd_data);
        pulse(cmd_err_clr);
        check("R11 framing cleared", framing_err, 0);

        // R7: break
        send_async(8'h00, 1'b0, 1'b0);
        ticks(20);
        check("R7 break high", lev_out, 1);
        check("R7 pin driven", lev_oe, 1);
        ser_in = 1'b1; ticks(1); @(negedge clk);
        check("R7 break ends", lev_out, 0);
        ticks(2);
        pulse(rd_data);
        pulse(cmd_err_clr);

        // R4: overrun
        send_async(8'h11, 1'b1, 1'b0);
        send_async(8'h22, 1'b1, 1'b0);
        check("R4 overrun set", overrun, 1);
        check("R4 newer data", rx_data, 8'h22);
        pulse(rd_data);
        pulse(cmd_err_clr);
        check("R11 overrun cleared", overrun, 0);

        // R1/R5 random
        for (int n = 0; n < 30; n++) begin
            logic [7:0] v;
            v = 8'($urandom);
            cfg_len = 2'($urandom); cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
            cfg_div64 = ($urandom % 5) == 0;
            send_async(v, 1'b1, 1'b0);
            check("R1 random data", rx_data, v & len_mask(cfg_len));
            check("R5 random no error", {parity_err, framing_err, overrun}, 0);
            pulse(rd_data);
        end
        cfg_div64 = 1'b0; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R8: internal sync hunt
        cfg_mode = 2'd1; cfg_sync_char = 8'h96;
        pulse(cmd_hunt);
        sync_bit(1); sync_bit(1); sync_bit(1);
        @(negedge clk); @(negedge clk);
        check("R8 no early sync", lev_out, 0);
        send_sync(8'h96, 1'b0);
        check("R8 sync detected", lev_out, 1);
        check("R8 sync char not delivered", char_ready, 0);
        send_sync(8'h3C, 1'b0);
        check("R8 char after sync", rx_data, 8'h3C);
        check("R8 ready", char_ready, 1);
        pulse(rd_data);
        pulse(rd_status);
        check("R9 status read clears", lev_out, 0);
        // R5 in sync mode
        cfg_len = 2'd1; cfg_par_en = 1'b1;
        send_sync(8'h2B, 1'b0);
        check("R5 sync data", rx_data, 8'h2B & len_mask(2'd1));
        check("R5 sync parity ok", parity_err, 0);
        pulse(rd_data);
        send_sync(8'h15, 1'b1);
        check("R5 sync parity bad", parity_err, 1);
        pulse(rd_data);
        pulse(cmd_err_clr);
        cfg_len = 2'd3; cfg_par_en = 1'b0;

        // R10: external sync
        cfg_mode = 2'd2;
        pulse(cmd_hunt);
        check("R10 pin is input", lev_oe, 0);
        for (int i = 0; i < 16; i++) sync_bit(1'($urandom));
        @(negedge clk); @(negedge clk);
        check("R10 no char while hunting", char_ready, 0);
        pulse(lev_in);
        send_sync(8'h5B, 1'b0);
        check("R10 char after ext sync", rx_data, 8'h5B);
        check("R10 ready", char_ready, 1);
        pulse(rd_data);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule